// File: doc/BRIEF.md
# Return Address Stack with Status-Word Pointer

This block keeps the return addresses of a small 8-bit core. It places eight entries in data RAM at byte addresses 8 through 23. Each entry is a pair of bytes. A 3-bit pointer picks the active entry, and that pointer sits in the low bits of the status word the block holds. A call or interrupt strobe saves the 12-bit program counter and the upper four status bits into the selected pair, then advances the pointer.

A return strobe steps the pointer back and reads the pair into the program counter output. A restoring return does the same. It also reloads the upper four status bits from the entry and pulses an output that lets the interrupt logic accept requests again.

Each operation makes two single-byte RAM transfers, and the block reports busy while they run. The RAM read is combinational: the read data belongs to the address shown in the same cycle. The core can load the status word directly while the block is idle.

Top module: `ret_stack`

## Requirements
- R1: After reset, psw_o is 0 (pointer 0), and busy_o, pc_valid_o, irq_rearm_o and ram_we_o are all 0.
- R2: A push writes two bytes. The first is pc[7:0] at address 8+2×SP. The second is {psw[7:4], pc[11:8]} at address 9+2×SP, with the status nibble in bits 7:4 and the PC high nibble in bits 3:0. SP is psw_o[2:0] when the strobe is accepted.
- R3: busy_o is 1 in the two cycles after an accepted strobe. The operation's results are visible in the third cycle, when busy_o is 0 again.
- R4: A return first decrements SP. It then reads address 8+2×SP as pc[7:0] and address 9+2×SP bits 3:0 as pc[11:8]. In the third cycle after the strobe, pc_o holds that value and pc_valid_o is 1 for exactly one cycle.
- R5: A plain return (ret_i) changes only the pointer field of psw_o, and irq_rearm_o stays 0.
- R6: A restoring return (retr_i) loads psw_o[7:4] from bits 7:4 of the high byte read. It pulses irq_rearm_o in the same cycle as pc_valid_o.
- R7: The pointer wraps modulo 8 in both directions, with no error indication. A ninth nested push overwrites the entry at addresses 8 and 9, and a return at pointer 0 reads the entry at addresses 22 and 23.
- R8: Strobes that arrive while busy_o is 1 are ignored. When strobes arrive together while idle, push_i wins over retr_i, and retr_i wins over ret_i.
- R9: psw_wr_i loads psw_i into the status word only when the block is idle and no strobe is present. It is ignored otherwise.
- R10: ram_we_o is 1 only during push transfers, and the block never writes outside addresses 8 to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Call or interrupt strobe |
| ret_i | input | 1 | Plain return strobe |
| retr_i | input | 1 | Restoring return strobe |
| pc_i | input | 12 | Program counter to save |
| psw_wr_i | input | 1 | Direct status word load |
| psw_i | input | 8 | Status word load value |
| psw_o | output | 8 | Status word, pointer in bits 2:0 |
| pc_o | output | 12 | Restored program counter |
| pc_valid_o | output | 1 | One-cycle pulse when pc_o is updated |
| irq_rearm_o | output | 1 | One-cycle pulse after a restoring return |
| busy_o | output | 1 | RAM transfers in progress |
| ram_addr_o | output | 5 | Data RAM byte address |
| ram_we_o | output | 1 | Data RAM write enable |
| ram_wdata_o | output | 8 | Data RAM write byte |
| ram_rdata_i | input | 8 | Data RAM read byte, combinational |

## Verification
The bench fills all eight levels with program counters that differ in both bytes. Each push saves a different status nibble, so a swapped byte, a wrong slot or a wrong nibble lane shows up in the RAM image. A ninth push and nine returns test wrap in both directions and the LIFO order across the wrap. Restoring and plain returns alternate while the live nibble differs from every saved one, so a missing or spurious nibble reload is visible. Further patterns send strobes during busy, strobes together and status loads against strobes, which separate the acceptance rules from the priority order.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PUSH_LO = 3'd1,
      ST_PUSH_HI = 3'd2,
      ST_POP_LO  = 3'd3,
      ST_POP_HI  = 3'd4
   } rs_state_e;
endpackage

// File: rtl/ret_stack_seq.sv
module ret_stack_seq
   import ret_stack_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push_i,
   input  logic      ret_i,
   input  logic      retr_i,
   output rs_state_e state_o,
   output logic      restoring_o,
   output logic      push_go_o,
   output logic      pop_go_o,
   output logic      push_last_o,
   output logic      pop_last_o,
   output logic      idle_free_o,
   output logic      busy_o
);
   rs_state_e st_q, st_d;
   logic      restoring_q;
   logic      idle;
   logic      any_pop;

   assign idle    = (st_q == ST_IDLE);
   assign any_pop = ret_i | retr_i;

   assign push_go_o   = idle & push_i;
   assign pop_go_o    = idle & ~push_i & any_pop;
   assign idle_free_o = idle & ~push_i & ~any_pop;
   assign push_last_o = (st_q == ST_PUSH_HI);
   assign pop_last_o  = (st_q == ST_POP_HI);
   assign busy_o      = ~idle;
   assign state_o     = st_q;
   assign restoring_o = restoring_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (push_i)       st_d = ST_PUSH_LO;
            else if (any_pop) st_d = ST_POP_LO;
         end
         ST_PUSH_LO: st_d = ST_PUSH_HI;
         ST_PUSH_HI: st_d = ST_IDLE;
         ST_POP_LO:  st_d = ST_POP_HI;
         ST_POP_HI:  st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         restoring_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (pop_go_o) restoring_q <= retr_i;
      end
   end

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && push_i) |=> (st_q != ST_PUSH_LO));

   // R8
   prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && push_i && retr_i) |=> (st_q == ST_PUSH_LO));

   // R3
   two_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PUSH_LO || st_q == ST_POP_LO) |=> busy_o ##1 !busy_o);
endmodule

// File: rtl/ret_stack_psw.sv
module ret_stack_psw #(
   parameter int DATA_W    = 8,
   parameter int SP_W      = 3,
   parameter int SAVE_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [DATA_W-1:0]    wr_data_i,
   input  logic                 inc_i,
   input  logic                 dec_i,
   input  logic                 restore_i,
   input  logic [SAVE_BITS-1:0] restore_nib_i,
   output logic [DATA_W-1:0]    psw_o,
   output logic [SP_W-1:0]      sp_o,
   output logic [SAVE_BITS-1:0] nib_o
);
   localparam int NIB_LSB = DATA_W - SAVE_BITS;

   logic [DATA_W-1:0] psw_q;

   initial begin
      assert (SP_W + SAVE_BITS <= DATA_W)
         else $error("pointer and saved bits overlap in status word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psw_q <= '0;
      end else if (wr_en_i) begin
         psw_q <= wr_data_i;
      end else begin
         if (inc_i)
            psw_q[SP_W-1:0] <= psw_q[SP_W-1:0] + 1'b1;
         else if (dec_i)
            psw_q[SP_W-1:0] <= psw_q[SP_W-1:0] - 1'b1;
         if (restore_i)
            psw_q[DATA_W-1:NIB_LSB] <= restore_nib_i;
      end
   end

   assign psw_o = psw_q;
   assign sp_o  = psw_q[SP_W-1:0];
   assign nib_o = psw_q[DATA_W-1:NIB_LSB];

   // R7
   sp_inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_en_i) |=> (sp_o == SP_W'($past(sp_o) + 1'b1)));

   // R7
   sp_dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !wr_en_i) |=> (sp_o == SP_W'($past(sp_o) - 1'b1)));
endmodule

// File: rtl/ret_stack_ram.sv
module ret_stack_ram
   import ret_stack_pkg::*;
#(
   parameter int PC_W      = 12,
   parameter int DATA_W    = 8,
   parameter int SAVE_BITS = 4,
   parameter int SP_W      = 3,
   parameter int BASE_ADDR = 8,
   parameter int ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  rs_state_e            state_i,
   input  logic                 restoring_i,
   input  logic                 push_go_i,
   input  logic [PC_W-1:0]      pc_i,
   input  logic [SAVE_BITS-1:0] nib_i,
   input  logic [SP_W-1:0]      sp_i,
   input  logic [DATA_W-1:0]    rdata_i,
   output logic [ADDR_W-1:0]    addr_o,
   output logic                 we_o,
   output logic [DATA_W-1:0]    wdata_o,
   output logic [SAVE_BITS-1:0] restore_nib_o,
   output logic [PC_W-1:0]      pc_o,
   output logic                 pc_valid_o,
   output logic                 rearm_o
);
   localparam int HI_PC_W = PC_W - DATA_W;
   localparam int PAD_W   = DATA_W - SAVE_BITS - HI_PC_W;
   localparam int DEPTH   = 1 << SP_W;
   localparam int TOP     = BASE_ADDR + 2 * DEPTH - 1;

   initial begin
      assert (HI_PC_W > 0) else $error("PC must exceed one byte");
      assert (PAD_W >= 0) else $error("PC high part and saved bits exceed a byte");
      assert (TOP < (1 << ADDR_W)) else $error("address width too small");
   end

   logic [PC_W-1:0]      pc_hold;
   logic [SAVE_BITS-1:0] nib_hold;
   logic [DATA_W-1:0]    lo_hold;
   logic [DATA_W-1:0]    hi_pack;
   logic                 hi_sel;
   logic                 is_push;

   generate
      if (PAD_W > 0) begin : g_pad
         assign hi_pack = {nib_hold, {PAD_W{1'b0}}, pc_hold[PC_W-1:DATA_W]};
      end else begin : g_tight
         assign hi_pack = {nib_hold, pc_hold[PC_W-1:DATA_W]};
      end
   endgenerate

   assign hi_sel  = (state_i == ST_PUSH_HI) || (state_i == ST_POP_HI);
   assign is_push = (state_i == ST_PUSH_LO) || (state_i == ST_PUSH_HI);

   assign addr_o  = ADDR_W'(BASE_ADDR) + ADDR_W'({sp_i, hi_sel});
   assign we_o    = is_push;
   assign wdata_o = (state_i == ST_PUSH_HI) ? hi_pack : pc_hold[DATA_W-1:0];
   assign restore_nib_o = rdata_i[DATA_W-1:DATA_W-SAVE_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_hold    <= '0;
         nib_hold   <= '0;
         lo_hold    <= '0;
         pc_o       <= '0;
         pc_valid_o <= 1'b0;
         rearm_o    <= 1'b0;
      end else begin
         if (push_go_i) begin
            pc_hold  <= pc_i;
            nib_hold <= nib_i;
         end
         if (state_i == ST_POP_LO) lo_hold <= rdata_i;
         pc_valid_o <= (state_i == ST_POP_HI);
         rearm_o    <= (state_i == ST_POP_HI) && restoring_i;
         if (state_i == ST_POP_HI)
            pc_o <= {rdata_i[HI_PC_W-1:0], lo_hold};
      end
   end

   // R10
   write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> (int'(addr_o) >= BASE_ADDR && int'(addr_o) <= TOP));

   // R2
   pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_PUSH_LO) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
   import ret_stack_pkg::*;
#(
   parameter int PC_W      = 12,
   parameter int DATA_W    = 8,
   parameter int SAVE_BITS = 4,
   parameter int SP_W      = 3,
   parameter int BASE_ADDR = 8,
   parameter int ADDR_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              ret_i,
   input  logic              retr_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic              psw_wr_i,
   input  logic [DATA_W-1:0] psw_i,
   output logic [DATA_W-1:0] psw_o,
   output logic [PC_W-1:0]   pc_o,
   output logic              pc_valid_o,
   output logic              irq_rearm_o,
   output logic              busy_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic              ram_we_o,
   output logic [DATA_W-1:0] ram_wdata_o,
   input  logic [DATA_W-1:0] ram_rdata_i
);
   localparam int NIB_LSB = DATA_W - SAVE_BITS;

   rs_state_e            state;
   logic                 restoring;
   logic                 push_go, pop_go, push_last, pop_last, idle_free;
   logic [SP_W-1:0]      sp;
   logic [SAVE_BITS-1:0] nib, restore_nib;

   ret_stack_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .ret_i       (ret_i),
      .retr_i      (retr_i),
      .state_o     (state),
      .restoring_o (restoring),
      .push_go_o   (push_go),
      .pop_go_o    (pop_go),
      .push_last_o (push_last),
      .pop_last_o  (pop_last),
      .idle_free_o (idle_free),
      .busy_o      (busy_o)
   );

   ret_stack_psw #(
      .DATA_W    (DATA_W),
      .SP_W      (SP_W),
      .SAVE_BITS (SAVE_BITS)
   ) u_psw (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en_i       (psw_wr_i & idle_free),
      .wr_data_i     (psw_i),
      .inc_i         (push_last),
      .dec_i         (pop_go),
      .restore_i     (pop_last & restoring),
      .restore_nib_i (restore_nib),
      .psw_o         (psw_o),
      .sp_o          (sp),
      .nib_o         (nib)
   );

   ret_stack_ram #(
      .PC_W      (PC_W),
      .DATA_W    (DATA_W),
      .SAVE_BITS (SAVE_BITS),
      .SP_W      (SP_W),
      .BASE_ADDR (BASE_ADDR),
      .ADDR_W    (ADDR_W)
   ) u_ram (
      .clk           (clk),
      .rst_n         (rst_n),
      .state_i       (state),
      .restoring_i   (restoring),
      .push_go_i     (push_go),
      .pc_i          (pc_i),
      .nib_i         (nib),
      .sp_i          (sp),
      .rdata_i       (ram_rdata_i),
      .addr_o        (ram_addr_o),
      .we_o          (ram_we_o),
      .wdata_o       (ram_wdata_o),
      .restore_nib_o (restore_nib),
      .pc_o          (pc_o),
      .pc_valid_o    (pc_valid_o),
      .rearm_o       (irq_rearm_o)
   );

   // R6
   rearm_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rearm_o |-> pc_valid_o);

   // R5
   plain_keeps_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_valid_o && !irq_rearm_o) |-> $stable(psw_o[DATA_W-1:NIB_LSB]));

   // R3
   busy_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_go || pop_go) |=> busy_o);

   // R10
   we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> busy_o);

   // R9
   psw_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !push_last && !pop_last) |=> $stable(psw_o));
endmodule

// File: tb/ret_stack_tb.sv
`timescale 1ns/1ps
module ret_stack_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 1'b0, ret_i = 1'b0, retr_i = 1'b0;
   logic [11:0] pc_i = '0;
   logic        psw_wr_i = 1'b0;
   logic [7:0]  psw_i = '0;
   logic [7:0]  psw_o;
   logic [11:0] pc_o;
   logic        pc_valid_o, irq_rearm_o, busy_o;
   logic [4:0]  ram_addr_o;
   logic        ram_we_o;
   logic [7:0]  ram_wdata_o, ram_rdata_i;

   logic [7:0]  mem [0:31];
   int          total = 0, bad = 0;
   int          valid_cnt = 0;
   bit          finished = 1'b0;

   logic [2:0]  sp_m = '0;
   logic [3:0]  nib_m = '0;
   logic        b3_m = 1'b0;
   logic [11:0] slot_pc [0:7];
   logic [3:0]  slot_nib [0:7];

   always #2.5 clk = ~clk;

   ret_stack u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .ret_i(ret_i), .retr_i(retr_i),
      .pc_i(pc_i), .psw_wr_i(psw_wr_i), .psw_i(psw_i), .psw_o(psw_o), .pc_o(pc_o),
      .pc_valid_o(pc_valid_o), .irq_rearm_o(irq_rearm_o), .busy_o(busy_o),
      .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o),
      .ram_rdata_i(ram_rdata_i)
   );

   assign ram_rdata_i = mem[ram_addr_o];
   always @(posedge clk) if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
   always @(posedge clk) if (rst_n && pc_valid_o) valid_cnt <= valid_cnt + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_psw();
      return {nib_m, b3_m, sp_m};
   endfunction

   task automatic set_psw(input logic [3:0] nib, input logic b3, input logic [2:0] sp);
      @(negedge clk);
      psw_wr_i = 1'b1; psw_i = {nib, b3, sp};
      @(negedge clk);
      psw_wr_i = 1'b0;
      nib_m = nib; b3_m = b3; sp_m = sp;
      chk(psw_o == exp_psw(), "R9 psw load", psw_o, exp_psw());
   endtask

   // push with optional simultaneous return strobes (R8 priority)
   task automatic do_push(input logic [11:0] pc, input bit also_ret, input bit also_retr);
      int lo, hi;
      @(negedge clk);
      push_i = 1'b1; ret_i = also_ret; retr_i = also_retr; pc_i = pc;
      @(negedge clk);
      push_i = 1'b0; ret_i = 1'b0; retr_i = 1'b0;
      chk(busy_o == 1'b1, "R3 busy first", busy_o, 1);
      @(negedge clk);
      chk(busy_o == 1'b1, "R3 busy second", busy_o, 1);
      @(negedge clk);
      chk(busy_o == 1'b0, "R3 busy clear", busy_o, 0);
      lo = 8 + 2 * int'(sp_m);
      hi = lo + 1;
      chk(mem[lo] == pc[7:0], "R2 low byte", mem[lo], pc[7:0]);
      chk(mem[hi] == {nib_m, pc[11:8]}, "R2 high byte", mem[hi], {nib_m, pc[11:8]});
      slot_pc[sp_m] = pc; slot_nib[sp_m] = nib_m;
      sp_m = sp_m + 3'd1;
      chk(psw_o == exp_psw(), "R7 pointer after push", psw_o, exp_psw());
   endtask

   task automatic do_pop(input bit plain, input bit restoring);
      int vc;
      vc = valid_cnt;
      @(negedge clk);
      ret_i = plain; retr_i = restoring;
      @(negedge clk);
      ret_i = 1'b0; retr_i = 1'b0;
      chk(busy_o == 1'b1, "R3 busy pop", busy_o, 1);
      @(negedge clk);
      chk(pc_valid_o == 1'b0, "R4 no early valid", pc_valid_o, 0);
      @(negedge clk);
      sp_m = sp_m - 3'd1;
      if (restoring) nib_m = slot_nib[sp_m];
      chk(pc_valid_o == 1'b1, "R4 valid pulse", pc_valid_o, 1);
      chk(pc_o == slot_pc[sp_m], "R4 pc restored", pc_o, slot_pc[sp_m]);
      chk(irq_rearm_o == restoring, restoring ? "R6 rearm" : "R5 no rearm",
          irq_rearm_o, restoring);
      chk(psw_o == exp_psw(), restoring ? "R6 nibble restored" : "R5 psw kept",
          psw_o, exp_psw());
      @(negedge clk);
      chk(pc_valid_o == 1'b0 && irq_rearm_o == 1'b0, "R4 single pulse",
          {pc_valid_o, irq_rearm_o}, 0);
      chk(valid_cnt == vc + 1, "R4 pulse count", valid_cnt, vc + 1);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = 8'hA5;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(psw_o == 8'h00 && busy_o == 0 && pc_valid_o == 0 && irq_rearm_o == 0 && ram_we_o == 0,
          "R1 reset", {psw_o, busy_o, pc_valid_o, irq_rearm_o, ram_we_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(psw_o == 8'h00 && busy_o == 0, "R1 after release", {psw_o, busy_o}, 0);

      // eight levels, each with its own saved nibble
      for (int i = 0; i < 8; i++) begin
         set_psw(4'(i + 5), i[0], sp_m);
         do_push(12'((i * 12'h1A3 + 12'h05C) & 12'hFFF), 1'b0, 1'b0);
      end
      chk(sp_m == 3'd0, "R7 wrapped to zero", psw_o[2:0], 0);
      // ninth push overwrites slot at 8/9 (R7)
      set_psw(4'h3, 1'b1, sp_m);
      do_push(12'hABC, 1'b0, 1'b0);
      chk(mem[8] == 8'hBC && mem[9] == 8'h3A, "R7 overwrite oldest",
          {mem[9], mem[8]}, 16'h3ABC);

      // nine returns across the underflow wrap, alternating kinds
      for (int i = 0; i < 9; i++) begin
         set_psw(4'hF, b3_m, sp_m);
         do_pop(i[0] == 1'b0, i[0] == 1'b1);
      end

      // strobes and status load during busy are ignored (R8, R9)
      set_psw(4'h9, 1'b0, 3'd2);
      @(negedge clk);
      push_i = 1'b1; pc_i = 12'h321;
      @(negedge clk);
      push_i = 1'b1; ret_i = 1'b1; pc_i = 12'hFED; psw_wr_i = 1'b1; psw_i = 8'hFF;
      @(negedge clk);
      push_i = 1'b0; ret_i = 1'b0; psw_wr_i = 1'b0;
      @(negedge clk);
      chk(mem[12] == 8'h21 && mem[13] == 8'h93, "R8 busy strobes ignored",
          {mem[13], mem[12]}, 16'h9321);
      slot_pc[2] = 12'h321; slot_nib[2] = 4'h9; sp_m = 3'd3;
      chk(psw_o == exp_psw(), "R9 load ignored while busy", psw_o, exp_psw());
      @(negedge clk);
      chk(busy_o == 1'b0 && psw_o == exp_psw(), "R8 no extra op", {busy_o, psw_o}, exp_psw());

      // priority: push beats returns
      do_push(12'h777, 1'b1, 1'b1);
      // priority: restoring beats plain
      set_psw(4'h0, 1'b0, sp_m);
      do_pop(1'b1, 1'b1);
      set_psw(4'h0, 1'b0, sp_m);
      do_pop(1'b1, 1'b0);

      // status load together with a strobe is ignored (R9)
      @(negedge clk);
      push_i = 1'b1; pc_i = 12'h0F0; psw_wr_i = 1'b1; psw_i = 8'h5D;
      @(negedge clk);
      push_i = 1'b0; psw_wr_i = 1'b0;
      repeat (2) @(negedge clk);
      slot_pc[sp_m] = 12'h0F0; slot_nib[sp_m] = nib_m; sp_m = sp_m + 3'd1;
      chk(psw_o == exp_psw(), "R9 load loses to strobe", psw_o, exp_psw());

      // R10 nothing written outside the stack window
      for (int a = 0; a < 32; a++) begin
         if (a < 8 || a > 23)
            chk(mem[a] == 8'hA5, "R10 outside window", mem[a], 8'hA5);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule